// File: doc/BRIEF.md
# Context Pair Compactor and Serializer

This block sits between a column-parallel context generator and an arithmetic encoder that takes one symbol per cycle. In each cycle the generator may offer one column word. The word has a fixed number of slots, and each slot holds a context label, a decision bit and a valid flag. The block keeps only the slots whose valid flag is set. It hands them to the encoder one pair per cycle over a valid/ready handshake, in ascending slot order. The producer arranges its slots in coding order: run-length and uniform symbols come first, then each row from top to bottom, with the main context of a row ahead of its sign context.

A column can yield anywhere from zero to ten pairs. The block therefore has two stores: an active word being drained and a one-word holding register. While the active word drains, the next column is accepted into the holding register. The upstream stall rises only when that register is occupied. When the last pair of the active word leaves, the held word becomes active on the same edge, so the output has no bubble between columns. A column with no valid slot is taken at once and uses no storage.

Top module: `ctx_pair_serializer`

## Requirements
- R1: After reset, `out_valid` and `in_stall` are both low.
- R2: Slot i occupies bits [7i+6:7i] of `in_word`, laid out as context in bits [4:0], decision in bit 5 and valid in bit 6. A slot with its valid bit clear is never emitted, whatever its other bits hold.
- R3: The valid slots of one word leave in ascending slot index.
- R4: `out_valid` is high exactly when some accepted pair has not yet been sent. With `out_ready` held high, one pair leaves per cycle.
- R5: While `out_valid` is high and `out_ready` is low, the presented pair stays unchanged in the next cycle.
- R6: A word with no valid slot is accepted in its cycle whenever `in_stall` is low, and it produces no output.
- R7: `in_stall` is high exactly when an accepted word with pairs is waiting behind a word that still has pairs to send. A word offered while `in_stall` is high is not taken.
- R8: A word accepted while another is draining starts its output in the cycle right after the previous word's last pair, with no idle cycle between them.
- R9: Words leave in the order they were accepted, and no pair is lost or sent twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A column word is offered |
| in_word | input | 70 | Ten 7-bit slots, laid out as given in R2 |
| in_stall | output | 1 | Upstream must hold its word; it is not taken this cycle |
| out_valid | output | 1 | A pair is presented to the encoder |
| out_ctx | output | 5 | Context label of the presented pair |
| out_dec | output | 1 | Decision bit of the presented pair |
| out_ready | input | 1 | Encoder takes the presented pair this cycle |

## Verification
The two events that overlap in one cycle are the last pair of the active word leaving and the acceptance or promotion of the next word. The bench provokes this with long runs of one-pair and sparse words under a continuously ready encoder, and with a held word promoted at the same edge the active word empties. A behavioural queue model predicts `out_valid`, `in_stall` and the presented pair every cycle. Any dropped, repeated or delayed pair, and any stall that rises too early or too late, therefore shows up as a mismatch in that cycle.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int CTX_W  = 5;
  localparam int SLOT_W = CTX_W + 2;

  // Slot layout: valid on top, then decision, then context label.
  typedef struct packed {
    logic             vld;
    logic             dec;
    logic [CTX_W-1:0] ctx;
  } slot_t;

  // Index of the lowest set bit; zero when no bit is set.
  function automatic logic [31:0] first_set(input logic [31:0] m);
    logic [31:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = 32'(i);
    end
    return r;
  endfunction

  // Mask with its lowest set bit removed.
  function automatic logic [31:0] drop_lowest(input logic [31:0] m);
    return m & (m - 32'd1);
  endfunction

endpackage

// File: rtl/cps_unpack.sv
module cps_unpack
  import cps_pkg::*;
#(
  parameter  int NSLOT = 10,
  localparam int WW    = NSLOT * SLOT_W
) (
  input  logic [WW-1:0]    word,
  output logic [NSLOT-1:0] mask
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_t s;
    assign s       = word[g*SLOT_W +: SLOT_W];
    assign mask[g] = s.vld;
  end

endmodule

// File: rtl/cps_pick.sv
module cps_pick
  import cps_pkg::*;
#(
  parameter  int NSLOT = 10,
  localparam int WW    = NSLOT * SLOT_W,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] mask,
  input  logic [WW-1:0]    word,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output slot_t            slot
);

  logic [31:0] pos;

  always_comb begin
    pos  = first_set(32'(mask));
    any  = |mask;
    idx  = pos[IDX_W-1:0];
    slot = word[idx*SLOT_W +: SLOT_W];
  end

endmodule

// File: rtl/cps_store.sv
module cps_store
  import cps_pkg::*;
#(
  parameter  int NSLOT = 10,
  localparam int WW    = NSLOT * SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [NSLOT-1:0] in_mask,
  input  logic [WW-1:0]    in_word,
  input  logic             fire,
  output logic [NSLOT-1:0] act_mask,
  output logic [WW-1:0]    act_word,
  output logic             hold_full,
  output logic             act_drained,
  output logic             hold_move,
  output logic             direct_load,
  output logic             hold_load
);

  logic [NSLOT-1:0] hold_mask;
  logic [WW-1:0]    hold_word;
  logic [NSLOT-1:0] mask_after;
  logic [31:0]      trimmed;
  logic             keep;

  always_comb begin
    trimmed     = drop_lowest(32'(act_mask));
    mask_after  = fire ? trimmed[NSLOT-1:0] : act_mask;
    act_drained = (mask_after == '0);
    keep        = take && (|in_mask);
    hold_move   = act_drained && hold_full;
    direct_load = act_drained && !hold_full && keep;
    hold_load   = keep && !act_drained;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask  <= '0;
      act_word  <= '0;
      hold_mask <= '0;
      hold_word <= '0;
      hold_full <= 1'b0;
    end else begin
      if (hold_move) begin
        act_mask <= hold_mask;
        act_word <= hold_word;
      end else if (direct_load) begin
        act_mask <= in_mask;
        act_word <= in_word;
      end else begin
        act_mask <= mask_after;
      end
      if (hold_load) begin
        hold_mask <= in_mask;
        hold_word <= in_word;
        hold_full <= 1'b1;
      end else if (hold_move) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R7: an occupied holding register is never overwritten before promotion.
  a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !hold_move |=> hold_full && $stable(hold_mask) && $stable(hold_word));

  // R7: a word is only parked while the active word still has pairs.
  a_r7_park_behind: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> act_mask != '0);

  // R8: a promoted word always carries at least one pair.
  a_r8_promote_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    hold_move |=> act_mask != '0);

endmodule

// File: rtl/ctx_pair_serializer.sv
module ctx_pair_serializer
  import cps_pkg::*;
#(
  parameter  int NSLOT = 10,
  localparam int WW    = NSLOT * SLOT_W,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WW-1:0]    in_word,
  output logic             in_stall,
  output logic             out_valid,
  output logic [CTX_W-1:0] out_ctx,
  output logic             out_dec,
  input  logic             out_ready
);

  logic [NSLOT-1:0] in_mask;
  logic [NSLOT-1:0] act_mask;
  logic [WW-1:0]    act_word;
  logic             hold_full;
  logic             act_drained;
  logic             hold_move;
  logic             direct_load;
  logic             hold_load;
  logic             take;
  logic             fire;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  slot_t            pick_slot;

  cps_unpack #(.NSLOT(NSLOT)) unpack_i (
    .word (in_word),
    .mask (in_mask)
  );

  assign in_stall = hold_full;
  assign take     = in_valid && !hold_full;
  assign fire     = out_valid && out_ready;

  cps_store #(.NSLOT(NSLOT)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .in_mask     (in_mask),
    .in_word     (in_word),
    .fire        (fire),
    .act_mask    (act_mask),
    .act_word    (act_word),
    .hold_full   (hold_full),
    .act_drained (act_drained),
    .hold_move   (hold_move),
    .direct_load (direct_load),
    .hold_load   (hold_load)
  );

  cps_pick #(.NSLOT(NSLOT)) pick_i (
    .mask (act_mask),
    .word (act_word),
    .any  (pick_any),
    .idx  (pick_idx),
    .slot (pick_slot)
  );

  assign out_valid = pick_any;
  assign out_ctx   = pick_slot.ctx;
  assign out_dec   = pick_slot.dec;

  // R5: a refused pair is presented again unchanged.
  a_r5_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ctx) && $stable(out_dec));

  // R3: within one word the next pair comes from a higher slot.
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !act_drained |=> out_valid && (pick_idx > $past(pick_idx)));

  // R2: the presented slot always carries its valid flag.
  a_r2_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pick_slot.vld);

  // R4: with nothing presented, nothing is parked either.
  a_r4_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !in_stall);

  // R6: an empty column taken while idle leaves the output idle.
  a_r6_empty_column: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_mask == '0) && !out_valid |=> !out_valid);

endmodule

// File: tb/ctx_pair_serializer_tb_top.sv
`timescale 1ns/1ps
module ctx_pair_serializer_tb_top;

  localparam int NS = 10;
  localparam int WW = NS * 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [WW-1:0] in_word;
  logic          in_stall;
  logic          out_valid;
  logic [4:0]    out_ctx;
  logic          out_dec;
  logic          out_ready;

  int checks = 0;
  int fails  = 0;
  int pairs_q[$];
  int words_q[$];

  always #2.5 clk = ~clk;

  ctx_pair_serializer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_stall  (in_stall),
    .out_valid (out_valid),
    .out_ctx   (out_ctx),
    .out_dec   (out_dec),
    .out_ready (out_ready)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Builds a word; invalid slots carry random junk in their other bits (R2).
  function automatic logic [WW-1:0] make_word(input int density);
    logic [WW-1:0] w;
    w = '0;
    for (int i = 0; i < NS; i++) begin
      w[i*7 +: 6] = 6'($urandom);
      w[i*7 + 6]  = (($urandom % 100) < density);
    end
    return w;
  endfunction

  // Word with exactly n valid slots at random distinct positions.
  function automatic logic [WW-1:0] word_with(input int n);
    logic [WW-1:0] w;
    int placed;
    w = make_word(0);
    placed = 0;
    while (placed < n) begin
      int k;
      k = $urandom % NS;
      if (!w[k*7 + 6]) begin
        w[k*7 + 6] = 1'b1;
        placed++;
      end
    end
    return w;
  endfunction

  // One cycle: drive, compare against the model, then advance it at the edge.
  task automatic step(input bit iv, input logic [WW-1:0] w, input bit rdy, output bit took);
    int  exp_v;
    int  exp_s;
    bit  fire;
    in_valid  = iv;
    in_word   = w;
    out_ready = rdy;
    #1;
    exp_v = (pairs_q.size() > 0);
    exp_s = (words_q.size() >= 2);
    chk(out_valid === exp_v[0], "R4 R8 out_valid", int'(out_valid), exp_v);
    chk(in_stall === exp_s[0], "R7 in_stall", int'(in_stall), exp_s);
    if (out_valid && pairs_q.size() > 0)
      chk({out_dec, out_ctx} == pairs_q[0][5:0], "R2 R3 R5 R9 pair",
          int'({out_dec, out_ctx}), pairs_q[0]);
    fire = out_valid && rdy && (pairs_q.size() > 0);
    took = iv && !in_stall;
    @(posedge clk);
    if (fire) begin
      void'(pairs_q.pop_front());
      words_q[0] = words_q[0] - 1;
      if (words_q[0] == 0) void'(words_q.pop_front());
    end
    if (took) begin
      int n;
      n = 0;
      for (int i = 0; i < NS; i++) begin
        if (w[i*7 + 6]) begin
          pairs_q.push_back(int'(w[i*7 +: 6]));
          n++;
        end
      end
      if (n > 0) words_q.push_back(n);
    end
    @(negedge clk);
  endtask

  task automatic push_word(input logic [WW-1:0] w, input int ready_pct);
    bit took;
    took = 1'b0;
    while (!took) step(1'b1, w, (($urandom % 100) < ready_pct), took);
  endtask

  task automatic drain();
    bit took;
    int guard;
    guard = 0;
    while ((pairs_q.size() > 0 || out_valid) && guard < 100) begin
      step(1'b0, '0, 1'b1, took);
      guard++;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    report();
  end

  initial begin
    bit took;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(in_stall === 1'b0, "R1 reset in_stall", int'(in_stall), 0);
    rst_n = 1'b1;

    // R6: empty column taken at once, nothing emitted.
    step(1'b1, make_word(0), 1'b1, took);
    chk(took, "R6 empty word taken", int'(took), 1);
    step(1'b0, '0, 1'b1, took);
    chk(out_valid === 1'b0, "R6 no output", int'(out_valid), 0);

    // R2: sparse word with junk in invalid slots.
    push_word(word_with(2), 100);
    drain();

    // R8 R9: variable per-column counts, encoder always ready.
    begin
      int cnt[10] = '{4, 2, 0, 0, 0, 2, 1, 2, 0, 0};
      foreach (cnt[i]) push_word(word_with(cnt[i]), 100);
    end
    drain();

    // R8: back-to-back one-pair words, last pair and promotion coincide.
    for (int i = 0; i < 40; i++) push_word(word_with(1), 100);
    drain();

    // R5: encoder backpressure on full words.
    for (int i = 0; i < 30; i++) push_word(word_with(10), 30);
    drain();

    // R7: stall on a parked word while the upstream keeps offering.
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 100) < 80, make_word($urandom % 100), ($urandom % 100) < 60, took);
    end
    drain();

    chk(pairs_q.size() == 0, "R9 all pairs delivered", pairs_q.size(), 0);
    report();
  end

endmodule